// File: doc/BRIEF.md
# Edge-Adaptive Three-Wire Register Port

This block is the slave side of a three-wire serial link (frame enable, serial clock, one bidirectional data line) in front of a 64 x 8-bit register file. The serial pins are oversampled by the system clock. Edges of the serial clock are detected inside the block, so the whole design runs in one clock domain.

Every frame opens with an 8-bit header. The header holds a 2-bit command code, sent least significant bit first, and then a 6-bit register address, sent most significant bit first. After the header the frame carries data bytes, most significant bit first. A read streams bytes out of consecutive registers for as long as the clock keeps running. A write stores each complete incoming byte into consecutive registers.

The serial-clock edge used to capture incoming bits is not fixed. It is chosen by the clock level at the first rising edge of enable after power-down, and it stays in force until the next power-down. Outgoing read bits change on the other edge.

Top module: `sreg_port`

## Requirements
- R1: After reset, `sdio_oe` is 0 and every register reads as 0x00.
- R2: At the first rising edge of `sen` after reset or power-down, the level of `sclk` picks the capture edge. A low level selects falling-edge capture and a high level selects rising-edge capture. The opposite edge is the launch edge, on which the port changes its output bit.
- R3: Once picked, the capture edge does not change on later `sen` rising edges, whatever the `sclk` level is at that moment. Only power-down or reset frees it.
- R4: Header bit 0 is C0 and header bit 1 is C1. C0=0, C1=1 is a read. C0=0, C1=0 is a write. Any code with C0=1 drives nothing and writes nothing for the rest of the frame.
- R5: Header bits 2..7 carry the address A5..A0 in that order. Data bytes travel D7 first and D0 last in both directions.
- R6: A read returns the addressed register and then the following registers, one per 8 launch edges. The address wraps from 63 to 0.
- R7: A write stores each byte and then advances to the next address. The address wraps from 63 to 0.
- R8: A write byte with fewer than 8 captured bits when `sen` falls is discarded, and the register keeps its value.
- R9: A low level on `sen` ends the frame. The next frame starts again with a fresh header.
- R10: `sdio_oe` is 1 only during the data phase of a read. It is 0 during every header, during writes, during code-C0=1 frames and while `sen` is low.
- R11: `pwr_down` releases the capture-edge choice, ends any frame and forces `sdio_oe` to 0. Register contents are kept.
- R12: A read cut short by `sen` falling has already delivered the leading bits of the addressed register, MSB first, unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_down | input | 1 | Synchronous power-down request |
| sen | input | 1 | Frame enable, high during a frame |
| sclk | input | 1 | Serial clock from the master |
| sdio | inout | 1 | Bidirectional serial data line |
| sdio_oe | output | 1 | High while the port drives `sdio` |

## Verification
The hardest situation to reach from the ports is the case where the capture edge already chosen disagrees with the clock level at a later enable rise. A careless design would re-select the edge there. The bench arms rising-edge capture with the clock high, ends the frame, parks the clock low, and opens a read. Only a port that keeps its first choice returns correct data, and the bench checks that data bit by bit. Power-down in mid-frame and a read cut after a few bits are directed cases. Random bursts with random start addresses, lengths and capture modes cover address wrap and both bit orders.

// File: rtl/sreg_pkg.sv
// Shared types for the three-wire register port.
// Assumes a 2-bit command code at the head of every frame.
package sreg_pkg;
    localparam int CODE_W = 2;

    typedef enum logic [1:0] {
        PH_HDR  = 2'd0,
        PH_WR   = 2'd1,
        PH_RD   = 2'd2,
        PH_SKIP = 2'd3
    } phase_t;
endpackage

// File: rtl/sreg_edge_sel.sv
// Front end of the serial port. Registers the pins into the system clock
// domain, picks the capture edge at the first enable rise after power-down,
// and turns serial clock transitions into one-cycle capture and launch events.
// Assumes the serial clock is far slower than clk, and that the master holds
// data stable around the capture edge.
module sreg_edge_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down,
    input  logic sen,
    input  logic sclk,
    input  logic sdi,
    output logic samp_ev,
    output logic xfer_ev,
    output logic frame_clr,
    output logic din
);
    logic sclk_s, sclk_d, en_s, en_d, din_s;
    logic armed, mode_rise;
    logic active, edge_seen, edge_is_samp;

    // Register the serial pins and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_s <= 1'b0;
            sclk_d <= 1'b0;
            en_s   <= 1'b0;
            en_d   <= 1'b0;
            din_s  <= 1'b0;
        end else begin
            sclk_s <= sclk;
            sclk_d <= sclk_s;
            en_s   <= sen;
            en_d   <= en_s;
            din_s  <= sdi;
        end
    end

    // Latch the capture edge once per power-up cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            mode_rise <= 1'b0;
        end else if (pwr_down) begin
            armed     <= 1'b0;
        end else if (en_s && !en_d && !armed) begin
            armed     <= 1'b1;
            mode_rise <= sclk_s;
        end
    end

    // Classify serial clock transitions inside an open frame.
    always_comb begin
        active       = armed && en_s && en_d && !pwr_down;
        edge_seen    = sclk_s ^ sclk_d;
        edge_is_samp = mode_rise ? sclk_s : !sclk_s;
        samp_ev      = active && edge_seen && edge_is_samp;
        xfer_ev      = active && edge_seen && !edge_is_samp;
        frame_clr    = !en_s || pwr_down;
        din          = din_s;
    end

    p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !pwr_down) |=> (armed && $stable(mode_rise)));

    p_pd_disarms_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> !armed);

    p_events_need_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_ev || xfer_ev) |-> armed);
endmodule

// File: rtl/sreg_frame.sv
// Frame engine. Collects the header, decodes the command, shifts write bytes
// in and read bytes out, and steps the register pointer after each byte.
// Assumes one capture or launch event per cycle at most and a frame_clr
// pulse whenever enable is low or power-down is active.
module sreg_frame #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_ev,
    input  logic              xfer_ev,
    input  logic              frame_clr,
    input  logic              din,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] ptr,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              dout,
    output logic              oe
);
    import sreg_pkg::*;

    localparam int HDR_W = CODE_W + ADDR_W;
    localparam int MAX_W = (HDR_W > DATA_W) ? HDR_W : DATA_W;
    localparam int CNT_W = $clog2(MAX_W);
    localparam int TX_W  = $clog2(DATA_W);

    phase_t            phase, next_phase;
    logic [CNT_W-1:0]  cnt;
    logic [TX_W-1:0]   tx_cnt;
    logic [HDR_W-1:0]  hdr_sh, hdr_full;
    logic [DATA_W-1:0] wr_sh, tx_sh;
    logic              code_c0, code_c1;

    // Assemble the header and pick the data phase from the command code.
    always_comb begin
        hdr_full = {hdr_sh[HDR_W-2:0], din};
        code_c0  = hdr_full[HDR_W-1];
        code_c1  = hdr_full[HDR_W-2];
        if (!code_c0 && code_c1)       next_phase = PH_RD;
        else if (!code_c0 && !code_c1) next_phase = PH_WR;
        else                           next_phase = PH_SKIP;
    end

    // Present a completed write byte to the register file.
    always_comb begin
        wr_data = {wr_sh[DATA_W-2:0], din};
        wr_en   = samp_ev && !frame_clr && (phase == PH_WR) &&
                  (cnt == CNT_W'(DATA_W - 1));
    end

    // Sequence the frame: header, then write or read bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_HDR;
            cnt    <= '0;
            tx_cnt <= '0;
            hdr_sh <= '0;
            wr_sh  <= '0;
            tx_sh  <= '0;
            ptr    <= '0;
            dout   <= 1'b0;
            oe     <= 1'b0;
        end else if (frame_clr) begin
            phase  <= PH_HDR;
            cnt    <= '0;
            tx_cnt <= '0;
            dout   <= 1'b0;
            oe     <= 1'b0;
        end else if (samp_ev) begin
            unique case (phase)
                PH_HDR: begin
                    hdr_sh <= hdr_full;
                    if (cnt == CNT_W'(HDR_W - 1)) begin
                        cnt   <= '0;
                        ptr   <= hdr_full[ADDR_W-1:0];
                        phase <= next_phase;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_WR: begin
                    wr_sh <= wr_data;
                    if (cnt == CNT_W'(DATA_W - 1)) begin
                        cnt <= '0;
                        ptr <= ptr + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end else if (xfer_ev && phase == PH_RD) begin
            oe <= 1'b1;
            if (tx_cnt == '0) begin
                dout  <= rd_data[DATA_W-1];
                tx_sh <= {rd_data[DATA_W-2:0], 1'b0};
            end else begin
                dout  <= tx_sh[DATA_W-1];
                tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            end
            if (tx_cnt == TX_W'(DATA_W - 1)) begin
                tx_cnt <= '0;
                ptr    <= ptr + 1'b1;
            end else begin
                tx_cnt <= tx_cnt + 1'b1;
            end
        end
    end

    p_drive_only_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> (phase == PH_RD));

    p_close_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_clr |=> (!oe && phase == PH_HDR && cnt == '0));

    p_write_steps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr == ADDR_W'($past(ptr) + 1'b1)));

    p_skip_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SKIP) |-> (!oe && !wr_en));
endmodule

// File: rtl/sreg_file.sv
// Register storage: 2**ADDR_W words of DATA_W bits with one write port and
// one combinational read port. Cleared by reset, untouched by power-down.
module sreg_file #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Clear on reset, store one word per write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Combinational read of the current pointer.
    always_comb rd_data = mem[rd_addr];
endmodule

// File: rtl/sreg_port.sv
// Top of the three-wire register port: pin front end, frame engine and
// register file, plus the tri-state driver of the shared data line.
// Assumes sen, sclk and sdio change slowly compared with clk.
module sreg_port #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down,
    input  logic sen,
    input  logic sclk,
    inout  wire  sdio,
    output logic sdio_oe
);
    logic              samp_ev, xfer_ev, frame_clr, din;
    logic              wr_en, dout, oe;
    logic [ADDR_W-1:0] ptr;
    logic [DATA_W-1:0] wr_data, rd_data;

    sreg_edge_sel u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_down  (pwr_down),
        .sen       (sen),
        .sclk      (sclk),
        .sdi       (sdio),
        .samp_ev   (samp_ev),
        .xfer_ev   (xfer_ev),
        .frame_clr (frame_clr),
        .din       (din)
    );

    sreg_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp_ev   (samp_ev),
        .xfer_ev   (xfer_ev),
        .frame_clr (frame_clr),
        .din       (din),
        .rd_data   (rd_data),
        .ptr       (ptr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .dout      (dout),
        .oe        (oe)
    );

    sreg_file #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (ptr),
        .wr_data (wr_data),
        .rd_addr (ptr),
        .rd_data (rd_data)
    );

    // Drive the shared line only while a read byte is being shifted out.
    assign sdio    = oe ? dout : 1'bz;
    assign sdio_oe = oe;

    p_pd_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> !sdio_oe);
endmodule

// File: tb/sreg_port_tb_top.sv
module sreg_port_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_down = 1'b0;
    logic sen = 1'b0;
    logic sclk = 1'b0;
    logic tb_oe = 1'b0;
    logic tb_bit = 1'b0;
    wire  sdio;
    logic sdio_oe;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] model [64];
    bit mode_rise_tb = 1'b0;
    bit armed_tb = 1'b0;
    bit oe_seen = 1'b0;

    assign sdio = tb_oe ? tb_bit : 1'bz;

    always #5 clk = ~clk;

    sreg_port dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .sen(sen),
        .sclk(sclk), .sdio(sdio), .sdio_oe(sdio_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One bit: move to the launch level, drive, then the capture edge.
    task automatic bit_cycle(input bit drive, input bit b, output bit got);
        bit pre;
        pre = mode_rise_tb ? 1'b0 : 1'b1;
        wait_n(1);
        sclk = pre;
        wait_n(3);
        tb_oe = drive;
        tb_bit = b;
        wait_n(3);
        got = sdio;
        if (sdio_oe) oe_seen = 1'b1;
        sclk = !pre;
        wait_n(3);
        tb_oe = 1'b0;
    endtask

    task automatic start_frame(input bit lvl);
        wait_n(2);
        sclk = lvl;
        wait_n(3);
        sen = 1'b1;
        if (!armed_tb) begin
            armed_tb = 1'b1;
            mode_rise_tb = lvl;
        end
        wait_n(3);
        oe_seen = 1'b0;
    endtask

    task automatic end_frame();
        wait_n(1);
        sen = 1'b0;
        tb_oe = 1'b0;
        wait_n(4);
    endtask

    task automatic power_down();
        wait_n(1);
        pwr_down = 1'b1;
        wait_n(3);
        sen = 1'b0;
        pwr_down = 1'b0;
        armed_tb = 1'b0;
        wait_n(3);
    endtask

    task automatic send_hdr(input bit c0, input bit c1, input logic [5:0] a);
        bit g;
        bit_cycle(1'b1, c0, g);
        bit_cycle(1'b1, c1, g);
        for (int i = 5; i >= 0; i--) bit_cycle(1'b1, a[i], g);
    endtask

    task automatic write_burst(input logic [5:0] a, input int n, input string req);
        bit g;
        logic [7:0] v;
        logic [5:0] p;
        p = a;
        send_hdr(1'b0, 1'b0, a);
        for (int k = 0; k < n; k++) begin
            v = 8'($urandom);
            for (int i = 7; i >= 0; i--) bit_cycle(1'b1, v[i], g);
            model[p] = v;
            p = p + 6'd1;
        end
        chk({req, " R10 no drive in write"}, 32'(oe_seen), 32'd0);
    endtask

    task automatic read_burst(input logic [5:0] a, input int n, input string req);
        bit g;
        logic [7:0] v;
        logic [5:0] p;
        p = a;
        send_hdr(1'b0, 1'b1, a);
        chk({req, " R10 no drive in header"}, 32'(oe_seen), 32'd0);
        for (int k = 0; k < n; k++) begin
            for (int i = 7; i >= 0; i--) begin
                bit_cycle(1'b0, 1'b0, g);
                v[i] = g;
            end
            chk({req, " R6 read byte"}, 32'(v), 32'(model[p]));
            p = p + 6'd1;
        end
    endtask

    initial begin
        int seed;
        bit g;
        logic [7:0] v;
        seed = $urandom(32'h5eed);
        for (int i = 0; i < 64; i++) model[i] = 8'h00;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(3);
        chk("R1 oe after reset", 32'(sdio_oe), 32'd0);

        // R1 / R2: falling-edge capture, whole file reads zero.
        start_frame(1'b0);
        read_burst(6'd0, 64, "R1");
        end_frame();
        chk("R9 oe released after frame", 32'(sdio_oe), 32'd0);

        // R7 / R6: write burst wrapping past 63, read back with wrap.
        start_frame(1'b0);
        write_burst(6'd61, 6, "R7");
        end_frame();
        start_frame(1'b0);
        read_burst(6'd61, 6, "R6");
        end_frame();

        // R2 / R3: arm rising capture with clock high, then open with clock low.
        power_down();
        start_frame(1'b1);
        write_burst(6'd20, 3, "R2");
        end_frame();
        start_frame(1'b0);
        read_burst(6'd20, 3, "R3");
        end_frame();
        start_frame(1'b1);
        read_burst(6'd19, 5, "R3");
        end_frame();

        // R5: address bit order, one-hot addresses.
        start_frame(1'b0);
        send_hdr(1'b0, 1'b0, 6'b000001);
        v = 8'h81;
        for (int i = 7; i >= 0; i--) bit_cycle(1'b1, v[i], g);
        model[1] = v;
        end_frame();
        start_frame(1'b0);
        read_burst(6'b100000, 1, "R5");
        end_frame();
        start_frame(1'b0);
        read_burst(6'b000001, 1, "R5");
        end_frame();

        // R8: full byte then a 5-bit fragment.
        start_frame(1'b1);
        send_hdr(1'b0, 1'b0, 6'd40);
        v = 8'h3c;
        for (int i = 7; i >= 0; i--) bit_cycle(1'b1, v[i], g);
        model[40] = v;
        for (int i = 0; i < 5; i++) bit_cycle(1'b1, 1'b1, g);
        end_frame();
        start_frame(1'b0);
        read_burst(6'd40, 2, "R8");
        end_frame();
        chk("R8 fragment discarded", 32'(model[41]), 32'h00);

        // R4: codes with C0=1 drive nothing and write nothing.
        for (int c = 0; c < 2; c++) begin
            start_frame(1'b0);
            send_hdr(1'b1, c[0], 6'd40);
            for (int i = 0; i < 16; i++) bit_cycle(1'b1, 1'b1, g);
            chk("R4 no drive on unused code", 32'(oe_seen), 32'd0);
            end_frame();
        end
        start_frame(1'b0);
        read_burst(6'd40, 2, "R4");
        end_frame();

        // R12 / R9: read cut after 3 bits, then a fresh frame works.
        model[10] = 8'hb5;
        start_frame(1'b0);
        send_hdr(1'b0, 1'b0, 6'd10);
        v = model[10];
        for (int i = 7; i >= 0; i--) bit_cycle(1'b1, v[i], g);
        end_frame();
        start_frame(1'b0);
        send_hdr(1'b0, 1'b1, 6'd10);
        v = 8'h00;
        for (int i = 7; i >= 5; i--) begin
            bit_cycle(1'b0, 1'b0, g);
            v[i] = g;
        end
        end_frame();
        chk("R12 partial read bits", 32'(v[7:5]), 32'(model[10][7:5]));
        start_frame(1'b0);
        read_burst(6'd9, 3, "R9");
        end_frame();

        // R11: power-down in a read and in a write; contents kept.
        start_frame(1'b0);
        send_hdr(1'b0, 1'b1, 6'd10);
        for (int i = 0; i < 3; i++) bit_cycle(1'b0, 1'b0, g);
        wait_n(1);
        pwr_down = 1'b1;
        wait_n(3);
        chk("R11 oe off in power-down", 32'(sdio_oe), 32'd0);
        sen = 1'b0;
        pwr_down = 1'b0;
        armed_tb = 1'b0;
        wait_n(3);
        start_frame(1'b1);
        send_hdr(1'b0, 1'b0, 6'd10);
        for (int i = 0; i < 4; i++) bit_cycle(1'b1, 1'b0, g);
        power_down();
        start_frame(1'b0);
        read_burst(6'd10, 1, "R11");
        end_frame();

        // Random bursts with random modes and power-downs.
        for (int it = 0; it < 16; it++) begin
            logic [5:0] a;
            int n;
            bit lvl;
            a = 6'($urandom);
            n = 1 + int'($urandom % 5);
            if (($urandom % 3) == 0) power_down();
            lvl = 1'($urandom);
            start_frame(lvl);
            write_burst(a, n, "R7");
            end_frame();
            lvl = 1'($urandom);
            start_frame(lvl);
            read_burst(a, n, "R6");
            end_frame();
        end

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule